// File: doc/BRIEF.md
# Round-robin slave arbiter with idle parking

This block decides which of several bus masters owns one shared slave port. Masters raise a request line. The owner keeps the port until the granted transfer signals that its access has ended. At that point the next owner is chosen in cyclic order. The cyclic search starts at the master just after the one that was granted last.

When no master is waiting, a static two-bit parking mode sets what the port does:
- It can drop every connection.
- It can stay with the master that used it last.
- It can return to a configured fixed master.

A master whose port is already parked on it starts its transfer in the same cycle as its request. This is flagged on a per-master zero-latency line. Any other master sees its grant one clock after its request.

The controller is a three-state machine:
- `ST_IDLE`: the slave is disconnected.
- `ST_PARK`: the slave is connected and no transfer is running.
- `ST_BUSY`: a transfer is running.

The transitions are:
- **idle-fix**: `ST_IDLE` to `ST_PARK` on the fixed master, in fixed mode.
- **idle-grant**: `ST_IDLE` to `ST_BUSY` on the cyclic winner.
- **park-hit**: `ST_PARK` to `ST_BUSY` on the parked master, with zero latency.
- **park-miss**: `ST_PARK` to `ST_BUSY` on the cyclic winner.
- **handover**: `ST_BUSY` to `ST_BUSY` on the next winner at end of access.
- **release**: `ST_BUSY` to `ST_IDLE` at end of access.
- **repark**: `ST_BUSY` to `ST_PARK` at end of access.

Top module: `rrpark_arbiter`

## Requirements
- R1: While reset is low and before the first clock edge after its release, `grant_o` is all zero, `owner_valid_o` is 0 and `zero_lat_o` is all zero. The cyclic pointer starts at master 0.
- R2: The mode encoding is 2'b00 = disconnect when idle, 2'b01 = park on the last owner, 2'b10 = park on the fixed master. The value 2'b11 behaves exactly like 2'b00.
- R3: When a grant is chosen by arbitration, the winner is the first requesting master in ascending cyclic order that starts one index after the last granted master. After reset, with all masters requesting, the order is 1, 2, 3, 0.
- R4: While a transfer is running and `access_done_i` is low, the grant does not change, whatever the request lines do.
- R5: In disconnect mode, an end of access with no request pending leaves `owner_valid_o` low and `grant_o` zero from the next cycle.
- R6: A master that requests while the slave is disconnected, or while the slave is parked on another master, has `zero_lat_o` low. Its grant appears one clock edge after its request.
- R7: In last-owner mode, an end of access with no request pending keeps the slave connected to the master that just finished.
- R8: A master that requests while the slave is parked on it has its grant bit and its `zero_lat_o` bit high in that same cycle. From the next cycle it owns a running transfer.
- R9: In fixed mode, the slave connects to `fixed_idx_i` at the first clock edge after reset. It returns there after any end of access with no request pending.
- R10: In fixed mode, when the fixed master and others request at an end of access, the cyclic order alone chooses the next owner.
- R11: `access_done_i` has no effect unless a transfer is running. A parked or disconnected slave with no requests keeps its grant.
- R12: `grant_o` is one-hot or zero. `owner_valid_o` is high exactly when some grant bit is high, and `owner_idx_o` is the index of that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_MASTERS | One request line per master |
| access_done_i | input | 1 | End-of-access strobe from the running transfer |
| park_mode_i | input | 2 | Idle parking mode (static) |
| fixed_idx_i | input | IDX_W | Fixed default master index (static) |
| grant_o | output | NUM_MASTERS | One-hot connection to the slave |
| owner_idx_o | output | IDX_W | Index of the connected master |
| owner_valid_o | output | 1 | Slave is connected to some master |
| zero_lat_o | output | NUM_MASTERS | Per-master flag: transfer starts this cycle without a latency cycle |

## Verification
All four mode codes are driven with random sticky requests and random end-of-access pulses. Directed cases run alongside them:
- Full request contention after reset pins down the starting point of the cyclic order.
- A parked master requesting alone, compared with a different master requesting, separates zero-latency grants from one-cycle grants.
- End-of-access pulses with and without pending requests separate handover from release and reparking.
- Pulses while parked or idle show whether the strobe is wrongly honoured outside a transfer.

// File: rtl/rrpark_pkg.sv
package rrpark_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_PARK = 2'b01,
        ST_BUSY = 2'b10
    } arb_state_e;

    typedef enum logic [1:0] {
        PM_NONE  = 2'b00,
        PM_LAST  = 2'b01,
        PM_FIXED = 2'b10,
        PM_RSVD  = 2'b11
    } park_mode_e;

endpackage

// File: rtl/rrpark_mode_decode.sv
module rrpark_mode_decode
    import rrpark_pkg::*;
(
    input  logic [1:0] raw_mode_i,
    output park_mode_e eff_mode_o
);

    // The reserved code folds onto disconnect-when-idle.
    always_comb begin
        unique case (raw_mode_i)
            2'b01:   eff_mode_o = PM_LAST;
            2'b10:   eff_mode_o = PM_FIXED;
            default: eff_mode_o = PM_NONE;
        endcase
    end

endmodule

// File: rtl/rrpark_rr_pick.sv
module rrpark_rr_pick #(
    parameter int NUM_MASTERS = 4,
    localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
    input  logic [NUM_MASTERS-1:0] req_i,
    input  logic [IDX_W-1:0]       last_i,
    output logic                   any_o,
    output logic [IDX_W-1:0]       win_o
);

    // Scan starts one past the last granted master and wraps; the last
    // granted master itself is examined last.
    always_comb begin
        any_o = 1'b0;
        win_o = '0;
        for (int k = 1; k <= NUM_MASTERS; k++) begin
            int c;
            c = (int'(last_i) + k) % NUM_MASTERS;
            if (!any_o && req_i[c]) begin
                any_o = 1'b1;
                win_o = IDX_W'(c);
            end
        end
    end

endmodule

// File: rtl/rrpark_grant_decode.sv
module rrpark_grant_decode #(
    parameter int NUM_MASTERS = 4,
    localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
    input  logic                   en_i,
    input  logic [IDX_W-1:0]       idx_i,
    output logic [NUM_MASTERS-1:0] onehot_o
);

    for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_bit
        assign onehot_o[g] = en_i && (idx_i == IDX_W'(g));
    end

endmodule

// File: rtl/rrpark_arbiter.sv
module rrpark_arbiter
    import rrpark_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] req_i,
    input  logic                   access_done_i,
    input  logic [1:0]             park_mode_i,
    input  logic [IDX_W-1:0]       fixed_idx_i,
    output logic [NUM_MASTERS-1:0] grant_o,
    output logic [IDX_W-1:0]       owner_idx_o,
    output logic                   owner_valid_o,
    output logic [NUM_MASTERS-1:0] zero_lat_o
);

    arb_state_e       state_q, state_d;
    logic [IDX_W-1:0] owner_q, owner_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;

    park_mode_e       eff_mode;
    logic             rr_any;
    logic [IDX_W-1:0] rr_win;
    logic             park_hit;
    logic             conn;
    logic [NUM_MASTERS-1:0] conn_vec;

    rrpark_mode_decode u_mode (
        .raw_mode_i (park_mode_i),
        .eff_mode_o (eff_mode)
    );

    rrpark_rr_pick #(.NUM_MASTERS(NUM_MASTERS)) u_pick (
        .req_i  (req_i),
        .last_i (ptr_q),
        .any_o  (rr_any),
        .win_o  (rr_win)
    );

    assign park_hit = (state_q == ST_PARK) && req_i[owner_q];
    assign conn     = (state_q != ST_IDLE);

    rrpark_grant_decode #(.NUM_MASTERS(NUM_MASTERS)) u_dec (
        .en_i     (conn),
        .idx_i    (owner_q),
        .onehot_o (conn_vec)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (eff_mode == PM_FIXED) begin
                    // idle-fix
                    state_d = ST_PARK;
                    owner_d = fixed_idx_i;
                end else if (rr_any) begin
                    // idle-grant
                    state_d = ST_BUSY;
                    owner_d = rr_win;
                    ptr_d   = rr_win;
                end
            end
            ST_PARK: begin
                if (park_hit) begin
                    // park-hit
                    state_d = ST_BUSY;
                    ptr_d   = owner_q;
                end else if (rr_any) begin
                    // park-miss
                    state_d = ST_BUSY;
                    owner_d = rr_win;
                    ptr_d   = rr_win;
                end
            end
            ST_BUSY: begin
                if (access_done_i) begin
                    if (rr_any) begin
                        // handover
                        owner_d = rr_win;
                        ptr_d   = rr_win;
                    end else begin
                        unique case (eff_mode)
                            PM_LAST:  state_d = ST_PARK;
                            PM_FIXED: begin
                                state_d = ST_PARK;
                                owner_d = fixed_idx_i;
                            end
                            default:  state_d = ST_IDLE;
                        endcase
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            ptr_q   <= ptr_d;
        end
    end

    // Outputs
    always_comb begin
        grant_o       = conn_vec;
        owner_idx_o   = owner_q;
        owner_valid_o = conn;
        zero_lat_o    = park_hit ? conn_vec : '0;
    end

    // R12
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o) && (owner_valid_o == (|grant_o)));

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && !access_done_i)
        |=> (state_q == ST_BUSY && $stable(owner_idx_o) && $stable(grant_o)));

    // R5
    none_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && access_done_i && !(|req_i) && eff_mode == PM_NONE)
        |=> (!owner_valid_o && grant_o == '0));

    // R7
    last_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && access_done_i && !(|req_i) && eff_mode == PM_LAST)
        |=> (owner_valid_o && owner_idx_o == $past(owner_idx_o)));

    // R9
    fixed_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && access_done_i && !(|req_i) && eff_mode == PM_FIXED)
        |=> (owner_valid_o && owner_idx_o == fixed_idx_i));

    // R8
    zero_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|zero_lat_o) |-> ((zero_lat_o & ~grant_o) == '0)
        ##1 (state_q == ST_BUSY && $stable(owner_idx_o)));

    // R11
    park_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARK && !(|req_i)) |=> $stable(grant_o));

endmodule

// File: tb/rrpark_arbiter_tb_top.sv
`timescale 1ns/1ps
module rrpark_arbiter_tb_top;

    localparam int N  = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic          done = 1'b0;
    logic [1:0]    cfg_mode = 2'b00;
    logic [IW-1:0] cfg_fix = '0;
    logic [N-1:0]  grant, zl;
    logic [IW-1:0] oidx;
    logic          ovalid;

    always #2 clk = ~clk;

    rrpark_arbiter #(.NUM_MASTERS(N)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (req),
        .access_done_i (done),
        .park_mode_i   (cfg_mode),
        .fixed_idx_i   (cfg_fix),
        .grant_o       (grant),
        .owner_idx_o   (oidx),
        .owner_valid_o (ovalid),
        .zero_lat_o    (zl)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state
    bit m_conn, m_busy;
    int m_own, m_ptr;

    function automatic int pick(logic [N-1:0] r, int p);
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (p + k) % N;
            if (r[c]) return c;
        end
        return -1;
    endfunction

    task automatic compare(string tag);
        logic [N-1:0] eg, ez;
        bit bad;
        eg = '0;
        ez = '0;
        bad = 0;
        if (m_conn) eg[m_own] = 1'b1;
        if (m_conn && !m_busy && req[m_own]) ez[m_own] = 1'b1;
        if (grant !== eg) begin
            $display("FAIL %s grant act=%b exp=%b", tag, grant, eg); bad = 1;
        end
        if (ovalid !== m_conn) begin
            $display("FAIL %s owner_valid act=%b exp=%b", tag, ovalid, m_conn); bad = 1;
        end
        if (m_conn && int'(oidx) != m_own) begin
            $display("FAIL %s owner_idx act=%0d exp=%0d", tag, oidx, m_own); bad = 1;
        end
        if (zl !== ez) begin
            $display("FAIL %s zero_lat act=%b exp=%b", tag, zl, ez); bad = 1;
        end
        n_chk++;
        if (bad) n_fail++;
    endtask

    task automatic model_step(logic [N-1:0] r, logic d);
        int em, w;
        em = (cfg_mode == 2'b11) ? 0 : int'(cfg_mode);
        w  = pick(r, m_ptr);
        if (!m_busy) begin
            if (!m_conn) begin
                if (em == 2) begin
                    m_conn = 1; m_own = int'(cfg_fix);
                end else if (w >= 0) begin
                    m_conn = 1; m_busy = 1; m_own = w; m_ptr = w;
                end
            end else if (r[m_own]) begin
                m_busy = 1; m_ptr = m_own;
            end else if (w >= 0) begin
                m_busy = 1; m_own = w; m_ptr = w;
            end
        end else if (d) begin
            if (w >= 0) begin
                m_own = w; m_ptr = w;
            end else begin
                m_busy = 0;
                if (em == 0) m_conn = 0;
                else if (em == 2) m_own = int'(cfg_fix);
            end
        end
    endtask

    task automatic cycle(logic [N-1:0] r, logic d, string tag);
        @(negedge clk);
        req  = r;
        done = d;
        #1;
        compare(tag);
        model_step(r, d);
    endtask

    task automatic do_reset(logic [1:0] mode, logic [IW-1:0] fix);
        @(negedge clk);
        rst_n = 1'b0;
        req = '0;
        done = 1'b0;
        cfg_mode = mode;
        cfg_fix = fix;
        m_conn = 0; m_busy = 0; m_own = 0; m_ptr = 0;
        repeat (2) @(negedge clk);
        #1;
        compare("R1");
        rst_n = 1'b1;
        model_step('0, 1'b0);
    endtask

    task automatic rand_phase(int cycles, string tag);
        logic [N-1:0] pend;
        pend = '0;
        for (int i = 0; i < cycles; i++) begin
            logic d;
            pend = pend | N'($urandom % (1 << N) & $urandom % (1 << N));
            if ($urandom % 10 == 0) pend = '0;
            d = m_busy ? ($urandom % 4 == 0) : ($urandom % 8 == 0);
            if (d && m_busy && ($urandom % 4 != 0)) pend[m_own] = 1'b0;
            cycle(pend, d, tag);
        end
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));

        // Fixed mode, fixed master 2
        do_reset(2'b10, 2'd2);
        cycle(4'b0000, 0, "R9");   // connected to fixed master
        cycle(4'b0100, 0, "R8");   // zero-latency start
        cycle(4'b0100, 0, "R4");
        cycle(4'b0000, 1, "R4");
        cycle(4'b0001, 0, "R6");   // other master: no zero-latency
        cycle(4'b0001, 0, "R6");   // granted one edge later
        cycle(4'b0110, 1, "R10");  // fixed master competes at end of access
        cycle(4'b0100, 0, "R10");  // master 1 won by cyclic order
        cycle(4'b0100, 1, "R3");
        cycle(4'b0000, 1, "R9");   // back to fixed
        cycle(4'b0000, 1, "R11");  // strobe while parked
        cycle(4'b0000, 0, "R11");
        rand_phase(1500, "R9 R10 R12");

        // Last-owner mode
        do_reset(2'b01, 2'd0);
        cycle(4'b1000, 0, "R6");
        cycle(4'b1000, 0, "R6");
        cycle(4'b0000, 1, "R7");
        cycle(4'b0000, 0, "R7");
        cycle(4'b1000, 0, "R8");
        cycle(4'b0000, 1, "R4");
        cycle(4'b0001, 0, "R6");
        cycle(4'b0001, 0, "R6");
        rand_phase(1500, "R7 R8 R12");

        // Disconnect mode, cyclic order from reset
        do_reset(2'b00, 2'd1);
        cycle(4'b0000, 1, "R11");
        cycle(4'b1111, 0, "R3");
        cycle(4'b1111, 1, "R3");   // owner 1
        cycle(4'b1111, 1, "R3");   // owner 2
        cycle(4'b1111, 1, "R3");   // owner 3
        cycle(4'b0000, 1, "R3");   // owner 0
        cycle(4'b0000, 0, "R5");
        rand_phase(1500, "R3 R5 R6 R12");

        // Reserved code
        do_reset(2'b11, 2'd3);
        cycle(4'b0010, 0, "R2");
        cycle(4'b0010, 0, "R2");
        cycle(4'b0000, 1, "R2");
        cycle(4'b0000, 0, "R2");
        rand_phase(1500, "R2 R4 R11");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule